// File: doc/BRIEF.md
# Bidirectional Shift and Rotate Unit

A purely combinational datapath block that moves the bits of a parameterised-width word by a signed distance. A three-bit operation code picks a shift or a rotate and its nominal direction. A flag marks the operand as signed, which makes right shifts arithmetic. The count is a two's-complement number; a negative value turns the operation around, so a caller can use one operation code for both directions.

Shift distances at or beyond the word width give a defined result: the word is cleared, or for an arithmetic right shift it is filled with copies of the sign bit. Rotate distances are reduced modulo the width. The result has no carry, overflow or status output and no register stage. It is meant to sit inside an execution pipeline where the surrounding stage supplies its timing.

Top module: `shift_rot_unit`

## Requirements
- R1: The operation code is `op_i` = 0 shift left, 1 shift right, 2 rotate left, 3 rotate right; codes 4 to 7 return `data_i` unchanged whatever the count and flag.
- R2: A left shift by c, 0 <= c <= WIDTH-1, gives result bit i = data bit i-c for i >= c and 0 for the c lowest bits.
- R3: A right shift by c, 0 <= c <= WIDTH-1, with `sgn_i` = 0 gives result bit i = data bit i+c for i+c <= WIDTH-1 and 0 in the c highest bits.
- R4: A right shift with `sgn_i` = 1 fills the vacated high bits with data bit WIDTH-1; a left shift always fills with 0, whatever the flag.
- R5: The count `cnt_i` is two's complement, CNT_W = $clog2(WIDTH)+2 bits wide. A negative count runs the selected shift or rotate in the opposite direction by the count's magnitude; the arithmetic fill of R4 follows the resulting direction.
- R6: A shift whose count magnitude is WIDTH or more returns all zeros, except an arithmetic right shift (R4), which returns WIDTH copies of data bit WIDTH-1.
- R7: A left rotate by c places data bit i at result position (i+c) mod WIDTH; a right rotate places data bit (i+c) mod WIDTH at position i.
- R8: A rotate uses the count magnitude modulo WIDTH, so a count of +WIDTH or -WIDTH returns `data_i` unchanged.
- R9: A count of zero returns `data_i` unchanged for every operation code and flag value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Operand word |
| op_i | input | 3 | Operation code (R1) |
| sgn_i | input | 1 | Operand is signed: right shifts replicate the top bit |
| cnt_i | input | CNT_W | Signed shift or rotate distance |
| res_o | output | WIDTH | Result word |

## Verification
Assertions check properties that hold for every input combination: a zero count leaves the word intact, rotates keep the number of set bits, a full-width rotate returns the operand, an oversize shift yields a uniform word, and logical shifts clear the bit they vacate at the edge. Exact bit placement, the arithmetic fill, the direction reversal for negative counts and the modulo reduction of rotates are shown only by the bench, which sweeps every operation code, both flag values and every count from -(WIDTH+2) to WIDTH+2 over a set of fixed and random operands on an 8-bit instance, comparing each result with a bit-by-bit model.

// File: rtl/srot_pkg.sv
package srot_pkg;
  localparam logic [2:0] OP_SHL = 3'd0;
  localparam logic [2:0] OP_SHR = 3'd1;
  localparam logic [2:0] OP_ROL = 3'd2;
  localparam logic [2:0] OP_ROR = 3'd3;

  function automatic logic op_is_shift(input logic [2:0] op);
    return (op == OP_SHL) || (op == OP_SHR);
  endfunction

  function automatic logic op_is_rot(input logic [2:0] op);
    return (op == OP_ROL) || (op == OP_ROR);
  endfunction

  function automatic logic op_base_left(input logic [2:0] op);
    return (op == OP_SHL) || (op == OP_ROL);
  endfunction
endpackage

// File: rtl/srot_cnt_dec.sv
module srot_cnt_dec #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH) + 2
) (
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic                     base_left_i,
  output logic                     dir_left_o,
  output logic                     over_o,
  output logic [$clog2(WIDTH)-1:0] sh_amt_o,
  output logic [$clog2(WIDTH)-1:0] rot_amt_o
);
  localparam int AW = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] W_C = CNT_W'(WIDTH);

  logic             neg;
  logic [CNT_W-1:0] mag;
  logic [CNT_W-1:0] rem_c;
  logic [AW-1:0]    rem_a;

  assign neg   = cnt_i[CNT_W-1];
  // magnitude of the most negative count still fits unsigned
  assign mag   = neg ? (~cnt_i + 1'b1) : cnt_i;
  assign over_o     = (mag >= W_C);
  assign dir_left_o = base_left_i ^ neg;
  assign sh_amt_o   = mag[AW-1:0];

  assign rem_c = mag % W_C;
  assign rem_a = rem_c[AW-1:0];

  // right rotate by r is left rotate by WIDTH-r
  always_comb begin
    if (dir_left_o || (rem_a == '0)) rot_amt_o = rem_a;
    else                              rot_amt_o = AW'(W_C - rem_c);
  end

  always_comb begin
    if (!over_o) assert (mag < W_C && {{(CNT_W-AW){1'b0}}, sh_amt_o} == mag) else $error("AST_SHAMT_RANGE"); // R2
  end
endmodule

// File: rtl/srot_rev.sv
module srot_rev #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign q_o[i] = d_i[WIDTH-1-i];
  end
endmodule

// File: rtl/srot_shifter.sv
module srot_shifter #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]         d_i,
  input  logic [$clog2(WIDTH)-1:0] amt_i,
  input  logic                     fill_i,
  output logic [WIDTH-1:0]         q_o
);
  localparam int AW = $clog2(WIDTH);

  logic [WIDTH-1:0] stage [AW+1];
  assign stage[0] = d_i;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [WIDTH-1:0] moved;
    assign moved = {stage[k][WIDTH-1-S:0], {S{fill_i}}};
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  assign q_o = stage[AW];
endmodule

// File: rtl/srot_rotator.sv
module srot_rotator #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]         d_i,
  input  logic [$clog2(WIDTH)-1:0] amt_i,
  output logic [WIDTH-1:0]         q_o
);
  localparam int AW = $clog2(WIDTH);

  logic [WIDTH-1:0] stage [AW+1];
  assign stage[0] = d_i;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [WIDTH-1:0] moved;
    assign moved = {stage[k][WIDTH-1-S:0], stage[k][WIDTH-1:WIDTH-S]};
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  // non power-of-two widths: amounts reach WIDTH-1 < 2**AW, stages compose
  assign q_o = stage[AW];

  always_comb begin
    assert ($countones(q_o) == $countones(d_i)) else $error("AST_ROT_ONES"); // R7
  end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import srot_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH) + 2
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [2:0]       op_i,
  input  logic             sgn_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int AW = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] W_C = CNT_W'(WIDTH);

  logic             dir_left, over, fill;
  logic [AW-1:0]    sh_amt, rot_amt;
  logic [WIDTH-1:0] data_rev, sh_in, sh_out, sh_out_rev, sh_res, rot_res;

  srot_cnt_dec #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_dec (
    .cnt_i       (cnt_i),
    .base_left_i (op_base_left(op_i)),
    .dir_left_o  (dir_left),
    .over_o      (over),
    .sh_amt_o    (sh_amt),
    .rot_amt_o   (rot_amt)
  );

  // right shifts reuse the left shifter between two bit reversals
  srot_rev #(.WIDTH(WIDTH)) i_rev_in (.d_i(data_i), .q_o(data_rev));
  assign sh_in = dir_left ? data_i : data_rev;
  assign fill  = sgn_i & data_i[WIDTH-1] & ~dir_left;

  srot_shifter #(.WIDTH(WIDTH)) i_shl (
    .d_i    (sh_in),
    .amt_i  (sh_amt),
    .fill_i (fill),
    .q_o    (sh_out)
  );

  srot_rev #(.WIDTH(WIDTH)) i_rev_out (.d_i(sh_out), .q_o(sh_out_rev));
  assign sh_res = over ? {WIDTH{fill}} : (dir_left ? sh_out : sh_out_rev);

  srot_rotator #(.WIDTH(WIDTH)) i_rot (
    .d_i   (data_i),
    .amt_i (rot_amt),
    .q_o   (rot_res)
  );

  always_comb begin
    if (op_is_shift(op_i))    res_o = sh_res;
    else if (op_is_rot(op_i)) res_o = rot_res;
    else                      res_o = data_i;
  end

  always_comb begin
    if (cnt_i == '0)
      assert (res_o == data_i) else $error("AST_ZERO_CNT"); // R9
    if (op_is_rot(op_i) && (cnt_i == W_C || cnt_i == -W_C))
      assert (res_o == data_i) else $error("AST_ROT_FULL"); // R8
    if (op_is_shift(op_i) && (cnt_i == W_C || cnt_i == -W_C))
      assert (res_o == '0 || res_o == '1) else $error("AST_OVER_UNIFORM"); // R6
    if (op_i == OP_SHL && !cnt_i[CNT_W-1] && cnt_i != '0 && cnt_i < W_C)
      assert (res_o[0] == 1'b0) else $error("AST_SHL_LSB"); // R2
    if (op_i == OP_SHR && !sgn_i && !cnt_i[CNT_W-1] && cnt_i != '0)
      assert (res_o[WIDTH-1] == 1'b0) else $error("AST_SHR_MSB"); // R3
  end
endmodule

// File: tb/test_shift_rot_unit.sv
module test_shift_rot_unit;
  localparam int W  = 8;
  localparam int CW = $clog2(W) + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]  data;
  logic [2:0]    op;
  logic          sgn;
  logic [CW-1:0] cnt;
  logic [W-1:0]  res;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  shift_rot_unit #(.WIDTH(W), .CNT_W(CW)) i_shift_rot_unit (
    .data_i (data),
    .op_i   (op),
    .sgn_i  (sgn),
    .cnt_i  (cnt),
    .res_o  (res)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int o,
                                         input bit s, input int c);
    logic [W-1:0] r = '0;
    bit  left;
    int  m;
    logic f;
    if (o > 3) return d;
    left = ((o == 0) || (o == 2)) ^ (c < 0);
    m = (c < 0) ? -c : c;
    if (o >= 2) begin
      m = m % W;
      for (int i = 0; i < W; i++)
        if (left) r[(i + m) % W] = d[i];
        else      r[i] = d[(i + m) % W];
    end else begin
      f = (!left && s) ? d[W-1] : 1'b0;
      for (int i = 0; i < W; i++)
        if (left) r[i] = (i - m >= 0) ? d[i-m] : f;
        else      r[i] = (i + m < W) ? d[i+m] : f;
    end
    return r;
  endfunction

  function automatic string tag_of(input int o, input bit s, input int c);
    int m = (c < 0) ? -c : c;
    if (o > 3)  return "R1";
    if (c == 0) return "R9";
    if (o >= 2) return (m >= W) ? "R8" : ((c < 0) ? "R5" : "R7");
    if (m >= W) return "R6";
    if (c < 0)  return "R5";
    if (o == 0) return "R2";
    return s ? "R4" : "R3";
  endfunction

  task automatic apply(input logic [W-1:0] d, input int o, input bit s, input int c);
    logic [W-1:0] exp_v;
    @(posedge clk);
    data = d; op = 3'(o); sgn = s; cnt = CW'(c);
    @(negedge clk);
    exp_v = model(d, o, s, c);
    total++;
    if (res !== exp_v) begin
      bad++;
      $display("FAIL %s op=%0d sgn=%0d cnt=%0d data=%h actual=%h expected=%h",
               tag_of(o, s, c), o, s, c, d, res, exp_v);
    end
  endtask

  logic [W-1:0] pats [12];

  initial begin
    data = '0; op = '0; sgn = 1'b0; cnt = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R9: zero count at start-up leaves operand intact
    apply(8'hA5, 0, 1'b0, 0);
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h80; pats[3] = 8'h01;
    pats[4] = 8'hA5; pats[5] = 8'h5A; pats[6] = 8'hC3; pats[7] = 8'h7F;
    for (int k = 8; k < 12; k++) pats[k] = 8'($urandom);
    // R1..R9: full sweep of codes, flag and counts -(W+2)..W+2
    for (int p = 0; p < 12; p++)
      for (int o = 0; o < 8; o++)
        for (int s = 0; s < 2; s++)
          for (int c = -(W + 2); c <= W + 2; c++)
            apply(pats[p], o, s[0], c);
    // R5, R6: extreme counts of the count range
    apply(8'h96, 1, 1'b1, -(1 << (CW - 1)));
    apply(8'h96, 0, 1'b1, (1 << (CW - 1)) - 1);
    apply(8'h96, 3, 1'b0, -(1 << (CW - 1)));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule